// File: doc/BRIEF.md
# Combined Interrupt Enable and Status Register

This block gathers up to eight event inputs into one byte-wide register. The same register serves two purposes. A write loads the per-source enable mask. A read returns the latched triggered status of the sources that are currently enabled. A rising edge on an enabled event input sets that source's status bit. The bit stays set until software clears the source's enable bit. A single registered interrupt request line stays high while any status bit is set.

There is no write-one-to-clear. A handler acknowledges an event by writing the enable mask with that source's bit cleared, which also clears the latched status. It then writes the bit back to re-arm the source. A parameter sets a fixed mask of the sources that exist. Bits outside that mask cannot be enabled and always read as zero.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset, `rd_data` and `irq_o` are 0 and every enable bit is cleared, so no event sets status until a write enables its source.
- R2: When `wr_en` is high at a clock edge, the enable mask becomes `wr_data` ANDed with `VALID_MASK`. Bit i of the mask controls event input i.
- R3: A 0-to-1 transition of `evt_i[i]`, sampled on two successive clock edges while source i is enabled, sets `rd_data[i]` at the second of those edges. An input held high does not set the bit again.
- R4: An edge on a source that is disabled at that edge is ignored. It is not set in status, and enabling the source later does not reveal it.
- R5: A set status bit holds until a write clears that source's enable bit. That write clears `rd_data[i]` at the same clock edge.
- R6: A write that sets an enable bit re-arms the source. A rising edge sampled at the same edge as that write is latched into status.
- R7: For any bit position that is 0 in `VALID_MASK`, `rd_data` always reads 0, whatever is written or driven on `evt_i`.
- R8: `irq_o` is a registered output equal to the OR of `rd_data`. It rises and falls at the same clock edge as the status change that causes it.
- R9: Writing 0 disables all sources and clears all status, and `irq_o` drops at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Event inputs, synchronous to clk |
| wr_en | input | 1 | Write strobe for the enable mask |
| wr_data | input | NUM_SRC | New enable mask |
| rd_data | output | NUM_SRC | Latched status of enabled sources |
| irq_o | output | 1 | Interrupt request, high while any status bit is set |

## Verification
The hardest cases to reach are the ones where a write and an event edge land on the same clock edge. One is a re-enabling write arriving with a fresh rising edge, which must be latched. The other is an enable bit rewritten while its input is still held high from the previous event, which must not fire again. The stimulus drives the event inputs and the write strobe together on the same falling edge so that both are sampled at one rising edge. It also leaves an input high across the disable/re-enable pair. A behavioural model compares `rd_data` and `irq_o` on every cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // Per-source register state: last sampled input, enable, latched status
    typedef struct packed {
        logic prev;
        logic en;
        logic st;
    } src_state_t;

    // Enable bit that is in force after this cycle's edge
    function automatic logic next_enable(input logic wr, input logic wbit, input logic cur);
        return wr ? wbit : cur;
    endfunction

endpackage

// File: rtl/evt_src_cell.sv
module evt_src_cell
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic wr_en,
    input  logic wr_bit,
    output logic en_o,
    output logic st_o,
    output logic st_nx_o
);

    src_state_t state_d, state_q;
    logic       en_nx;
    logic       rise;

    always_comb begin
        state_d      = state_q;
        en_nx        = next_enable(wr_en, wr_bit, state_q.en);
        rise         = evt_i & ~state_q.prev;
        state_d.prev = evt_i;
        state_d.en   = en_nx;
        state_d.st   = en_nx & (state_q.st | rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign en_o    = state_q.en;
    assign st_o    = state_q.st;
    assign st_nx_o = state_d.st;

    AST_EN_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (en_o == $past(wr_bit))); // R2
    AST_DISABLED_EDGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !wr_en) |=> !st_o); // R4
    AST_EDGE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && !wr_en && evt_i && !state_q.prev) |=> st_o); // R3
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit) |=> !st_o); // R5
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_o && !(wr_en && !wr_bit)) |=> st_o); // R5
    AST_REARM_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit && evt_i && !state_q.prev) |=> st_o); // R6

endmodule

// File: rtl/evt_irq_reqgen.sv
module evt_irq_reqgen #(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] st_nx,
    input  logic [NUM_SRC-1:0] st_q,
    output logic               irq_o
);

    typedef struct packed {
        logic irq;
    } req_state_t;

    req_state_t req_d, req_q;

    always_comb begin
        req_d     = req_q;
        req_d.irq = |st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign irq_o = req_q.irq;

    AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|st_q)); // R8

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
    parameter int                 NUM_SRC    = 8,
    parameter logic [NUM_SRC-1:0] VALID_MASK = 8'hB7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] rd_data,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] st_q;
    logic [NUM_SRC-1:0] st_nx;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (VALID_MASK[i]) begin : g_present
            evt_src_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .evt_i   (evt_i[i]),
                .wr_en   (wr_en),
                .wr_bit  (wr_data[i]),
                .en_o    (en_q[i]),
                .st_o    (st_q[i]),
                .st_nx_o (st_nx[i])
            );
        end else begin : g_absent
            assign en_q[i]  = 1'b0;
            assign st_q[i]  = 1'b0;
            assign st_nx[i] = 1'b0;
        end
    end

    evt_irq_reqgen #(.NUM_SRC(NUM_SRC)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .st_nx (st_nx),
        .st_q  (st_q),
        .irq_o (irq_o)
    );

    assign rd_data = st_q;

    AST_STATUS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q & ~en_q) == '0); // R5
    AST_WRITE_ZERO_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == '0) |=> !irq_o); // R9

endmodule

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;

    localparam int         CLK_PERIOD = 10;
    localparam int         N          = 8;
    localparam logic [7:0] VMASK      = 8'hB7;
    localparam int         WD_LIMIT   = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic         wr_en = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] rd_data;
    logic         irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    logic [N-1:0] m_prev = '0, m_en = '0, m_st = '0;
    logic         m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_ctrl #(.NUM_SRC(N), .VALID_MASK(VMASK)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    // Behavioural reference model, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev <= '0; m_en <= '0; m_st <= '0; m_irq <= 1'b0;
        end else begin
            logic [N-1:0] ne, ns;
            ne = wr_en ? (wr_data & VMASK) : m_en;
            ns = '0;
            for (int i = 0; i < N; i++) begin
                if (ne[i] && (m_st[i] || (evt_i[i] && !m_prev[i]))) ns[i] = 1'b1;
            end
            m_prev <= evt_i; m_en <= ne; m_st <= ns; m_irq <= (ns != 0);
        end
    end

    // Per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_tests++;
            if (rd_data !== m_st) begin
                n_fail++;
                $display("FAIL R3 model rd_data actual=%h expected=%h", rd_data, m_st);
            end
            n_tests++;
            if (irq_o !== m_irq) begin
                n_fail++;
                $display("FAIL R8 model irq_o actual=%b expected=%b", irq_o, m_irq);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive on the falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic w, input logic [N-1:0] wd, input logic [N-1:0] ev);
        wr_en = w; wr_data = wd; evt_i = ev;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rd_data in reset", rd_data, 0);
        chk("R1 irq in reset", irq_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rd_data after reset", rd_data, 0);
        // R1: no enable yet, an edge is ignored
        step(0, 0, 8'h01);
        chk("R1 edge before enable", rd_data, 0);
        step(0, 0, 8'h00);

        // R2 / R7: enable everything, invalid bits never set
        step(1, 8'hFF, 8'h00);
        step(0, 0, 8'h48);
        chk("R7 invalid sources read zero", rd_data, 0);
        chk("R2 invalid enable bits inert irq", irq_o, 0);
        step(0, 0, 8'h00);

        // R3 / R8: rising edge on source 0
        step(0, 0, 8'h01);
        chk("R3 edge sets status", rd_data, 8'h01);
        chk("R8 irq high with status", irq_o, 1);
        step(0, 0, 8'h01);
        chk("R3 level holds status only", rd_data, 8'h01);

        // R5: disable source 0 clears status at the write edge
        step(1, 8'hFE, 8'h01);
        chk("R5 disable clears status", rd_data, 8'h00);
        chk("R8 irq drops with status", irq_o, 0);
        // R3: re-enable with input still high: no new edge
        step(1, 8'hFF, 8'h01);
        chk("R3 held level does not retrigger", rd_data, 8'h00);
        step(0, 0, 8'h00);

        // R4: pulse on disabled source 1, then enable
        step(1, 8'hFD, 8'h00);
        step(0, 0, 8'h02);
        step(0, 0, 8'h00);
        chk("R4 disabled edge ignored", rd_data, 8'h00);
        step(1, 8'hFF, 8'h00);
        chk("R4 enable does not reveal old edge", rd_data, 8'h00);

        // R6: re-enabling write with same-cycle edge on source 2
        step(1, 8'hFB, 8'h00);
        step(1, 8'hFF, 8'h04);
        chk("R6 same-cycle edge latched", rd_data, 8'h04);

        // R5: status holds across idle cycles; multiple sources accumulate
        step(0, 0, 8'h14);
        step(0, 0, 8'h35);
        repeat (4) step(0, 0, 8'h00);
        chk("R5 status holds", rd_data, 8'h35);
        chk("R8 irq while status set", irq_o, 1);

        // Handler-style acknowledge of source 4 only
        step(1, 8'hEF, 8'h00);
        chk("R5 selective acknowledge", rd_data, 8'h25);
        step(1, 8'hFF, 8'h00);
        chk("R6 re-arm keeps others", rd_data, 8'h25);

        // R9: write zero clears all
        step(1, 8'h00, 8'h00);
        chk("R9 write zero clears status", rd_data, 8'h00);
        chk("R9 write zero drops irq", irq_o, 0);
        step(0, 0, 8'hFF);
        chk("R9 all disabled after zero", rd_data, 8'h00);
        step(0, 0, 8'h00);

        // Walk a range of masks and event patterns against the model
        for (int k = 0; k < 64; k++) begin
            logic [7:0] m, e;
            m = 8'(k * 37 + 11);
            e = 8'(k * 53 + 7);
            step((k % 3) == 0, m, e);
        end
        chk("R7 invalid bits zero after sweep", rd_data & ~VMASK, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule